// File: doc/BRIEF.md
# Submission Port Descriptor Validator

This block sits behind a four-dword submission port. Software writes the four 32-bit dwords into a small bank, one at a time, and then pulses a start strobe. The block pairs the dwords into two 64-bit context descriptors, checks each one's valid, privilege and addressing-mode fields, and decides whether the submission as a whole can be accepted.

A rejected submission produces a one-cycle error pulse with a reason code and issues nothing. An accepted submission is handed to a downstream workload queue over a valid/ready stream, one descriptor per transfer, in index order. Only the first transfer of a submission is marked as the schedule-in point. Each transfer also carries a flag that says whether the descriptor asks for a 4-level page table (set) or a 3-level one (clear).

The stream follows the usual valid/ready rules. Once `out_valid` is high, it stays high and `out_desc`, `out_first` and `out_deep` stay unchanged until a cycle where `out_ready` is also high. The transfer completes on that edge. The downstream side may hold `out_ready` low for any number of cycles. The block never withdraws an offered descriptor.

Top module: `sub_port_validator`

## Requirements
- R1: A write with `dw_we` high stores `dw_data` into dword `dw_sel` (0..3) on that clock edge. Descriptor 0 is {dword 3, dword 2} and descriptor 1 is {dword 1, dword 0}, with the higher-numbered dword as the upper half. A write in the same cycle as the start strobe is not seen by that submission.
- R2: Within a descriptor, bit 0 is the valid flag, bit 8 is the privilege flag and bits 4:3 are the addressing mode. A descriptor with bit 0 clear is skipped, and none of its other fields are checked.
- R3: If any valid descriptor has its privilege bit clear, the submission is rejected with code 3 and nothing is issued. This check takes priority over every other reason.
- R4: A submission in which neither descriptor is valid is rejected with code 1.
- R5: A submission in which descriptor 1 is valid and descriptor 0 is not is rejected with code 2.
- R6: A valid descriptor whose mode is neither 1 nor 3 causes rejection with code 4. On an issued descriptor, `out_deep` is 0 for mode 1 and 1 for mode 3.
- R7: Accepted descriptors are issued in index order, descriptor 0 first. `out_first` is 1 on the first transfer of a submission and 0 on any later one.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_desc`, `out_first` and `out_deep` hold their values on the next cycle.
- R9: A start strobe that arrives while `busy` is high is ignored. `overrun` pulses for one cycle after that edge, and the issue in progress continues unchanged.
- R10: After reset, `out_valid`, `busy`, `err_pulse` and `overrun` are 0. For a rejected submission, `err_pulse` is high for exactly the one cycle after the strobe edge, with `err_code` valid, and `busy` stays 0.
- R11: For an accepted submission, `out_valid` and `busy` rise in the cycle after the strobe edge. Both fall after the handshake of the last descriptor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dw_we | input | 1 | Dword write enable |
| dw_sel | input | 2 | Index of the dword being written |
| dw_data | input | 32 | Dword write data |
| go | input | 1 | Start strobe for the stored submission |
| out_valid | output | 1 | Descriptor offered downstream |
| out_ready | input | 1 | Downstream accepts the offered descriptor |
| out_desc | output | 64 | Offered descriptor |
| out_first | output | 1 | Schedule-in marker, set on the first transfer only |
| out_deep | output | 1 | 1 for a 4-level page table, 0 for a 3-level one |
| busy | output | 1 | An issue sequence is in progress |
| err_pulse | output | 1 | One-cycle rejection pulse |
| err_code | output | 3 | Rejection reason: 1 none valid, 2 order, 3 privilege, 4 mode |
| overrun | output | 1 | One-cycle pulse for a strobe ignored while busy |

## Verification
A table of submissions covers the following patterns:
- both descriptors good;
- descriptor 0 alone;
- neither valid;
- descriptor 1 alone;
- a privilege fault on either descriptor;
- a bad mode on either descriptor.

The two-descriptor cases tell correct dword pairing and ordering apart from swapped halves. The single-descriptor case shows that invalid entries are skipped rather than issued.

An invalid descriptor carrying a clear privilege bit separates "skip invalid" from "check everything". A case with a privilege fault alongside the order fault fixes which reason wins.

Directed tests hold `out_ready` low to expose any change while back-pressured. They also strobe during an issue to confirm that the strobe is ignored and flagged.

// File: rtl/sub_pkg.sv
package sub_pkg;
  localparam int DWORD_W   = 32;
  localparam int DESC_W    = 2 * DWORD_W;
  localparam int NUM_DW    = 4;
  localparam int NUM_DESC  = 2;
  localparam int VALID_POS = 0;
  localparam int PRIV_POS  = 8;
  localparam int MODE_LO   = 3;
  localparam int MODE_W    = 2;

  localparam logic [MODE_W-1:0] MODE_SHALLOW = 2'd1;
  localparam logic [MODE_W-1:0] MODE_DEEP    = 2'd3;

  typedef enum logic [2:0] {
    REJ_NONE  = 3'd0,
    REJ_EMPTY = 3'd1,
    REJ_ORDER = 3'd2,
    REJ_PRIV  = 3'd3,
    REJ_MODE  = 3'd4
  } rej_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } iss_state_e;
endpackage

// File: rtl/sub_dword_bank.sv
module sub_dword_bank #(
  parameter int DW = 32,
  parameter int N  = 4,
  localparam int SW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [SW-1:0]   sel,
  input  logic [DW-1:0]   wdata,
  output logic [N*DW-1:0] bank_q
);
  for (genvar g = 0; g < N; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q <= '0;
      else if (we && (sel == SW'(g)))
        word_q <= wdata;
    end
    assign bank_q[g*DW +: DW] = word_q;
  end
endmodule

// File: rtl/sub_desc_check.sv
module sub_desc_check
  import sub_pkg::*;
#(
  parameter int DW = 32,
  localparam int DESC = 2 * DW
) (
  input  logic [4*DW-1:0]     bank,
  output logic [DESC-1:0]     desc0,
  output logic [DESC-1:0]     desc1,
  output logic [NUM_DESC-1:0] vld,
  output logic [NUM_DESC-1:0] deep,
  output rej_e                verdict
);
  logic [DESC-1:0]     d [NUM_DESC];
  logic [NUM_DESC-1:0] priv_ok;
  logic [NUM_DESC-1:0] mode_ok;

  // Descriptor i takes the dword pair that starts at 2*(1-i)
  for (genvar i = 0; i < NUM_DESC; i++) begin : g_desc
    localparam int BASE = 2 * (NUM_DESC - 1 - i) * DW;
    logic [MODE_W-1:0] mode;
    assign d[i]       = bank[BASE +: DESC];
    assign mode       = d[i][MODE_LO +: MODE_W];
    assign vld[i]     = d[i][VALID_POS];
    assign priv_ok[i] = d[i][PRIV_POS];
    assign mode_ok[i] = (mode == MODE_SHALLOW) || (mode == MODE_DEEP);
    assign deep[i]    = (mode == MODE_DEEP);
  end

  assign desc0 = d[0];
  assign desc1 = d[1];

  always_comb begin
    if (|(vld & ~priv_ok))
      verdict = REJ_PRIV;
    else if (vld == '0)
      verdict = REJ_EMPTY;
    else if (!vld[0])
      verdict = REJ_ORDER;
    else if (|(vld & ~mode_ok))
      verdict = REJ_MODE;
    else
      verdict = REJ_NONE;
  end
endmodule

// File: rtl/sub_issue_ctrl.sv
module sub_issue_ctrl
  import sub_pkg::*;
#(
  parameter int DESC = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [DESC-1:0] desc0,
  input  logic [DESC-1:0] desc1,
  input  logic            vld1,
  input  logic [1:0]      deep,
  input  rej_e            verdict,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [DESC-1:0] out_desc,
  output logic            out_first,
  output logic            out_deep,
  output logic            busy,
  output logic            err_pulse,
  output logic [2:0]      err_code,
  output logic            overrun
);
  iss_state_e      state_q;
  logic            sel_q;
  logic            two_q;
  logic [DESC-1:0] hold0_q, hold1_q;
  logic [1:0]      deep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sel_q     <= 1'b0;
      two_q     <= 1'b0;
      hold0_q   <= '0;
      hold1_q   <= '0;
      deep_q    <= '0;
      err_pulse <= 1'b0;
      err_code  <= '0;
      overrun   <= 1'b0;
    end else begin
      err_pulse <= 1'b0;
      overrun   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (go) begin
            if (verdict != REJ_NONE) begin
              err_pulse <= 1'b1;
              err_code  <= verdict;
            end else begin
              state_q <= ST_ISSUE;
              sel_q   <= 1'b0;
              two_q   <= vld1;
              hold0_q <= desc0;
              hold1_q <= desc1;
              deep_q  <= deep;
            end
          end
        end
        ST_ISSUE: begin
          if (go)
            overrun <= 1'b1;
          if (out_ready) begin
            if (!sel_q && two_q)
              sel_q <= 1'b1;
            else
              state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q == ST_ISSUE);
  assign out_valid = busy;
  assign out_desc  = sel_q ? hold1_q : hold0_q;
  assign out_first = !sel_q;
  assign out_deep  = sel_q ? deep_q[1] : deep_q[0];
endmodule

// File: rtl/sub_port_validator.sv
module sub_port_validator
  import sub_pkg::*;
#(
  parameter int DW = DWORD_W,
  localparam int DESC = 2 * DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dw_we,
  input  logic [1:0]      dw_sel,
  input  logic [DW-1:0]   dw_data,
  input  logic            go,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DESC-1:0] out_desc,
  output logic            out_first,
  output logic            out_deep,
  output logic            busy,
  output logic            err_pulse,
  output logic [2:0]      err_code,
  output logic            overrun
);
  logic [NUM_DW*DW-1:0] bank;
  logic [DESC-1:0]      desc0, desc1;
  logic [NUM_DESC-1:0]  vld, deep;
  rej_e                 verdict;

  sub_dword_bank #(.DW(DW), .N(NUM_DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(dw_we), .sel(dw_sel),
    .wdata(dw_data), .bank_q(bank)
  );

  sub_desc_check #(.DW(DW)) u_check (
    .bank(bank), .desc0(desc0), .desc1(desc1),
    .vld(vld), .deep(deep), .verdict(verdict)
  );

  sub_issue_ctrl #(.DESC(DESC)) u_issue (
    .clk(clk), .rst_n(rst_n), .go(go),
    .desc0(desc0), .desc1(desc1), .vld1(vld[1]), .deep(deep),
    .verdict(verdict), .out_ready(out_ready),
    .out_valid(out_valid), .out_desc(out_desc), .out_first(out_first),
    .out_deep(out_deep), .busy(busy), .err_pulse(err_pulse),
    .err_code(err_code), .overrun(overrun)
  );
endmodule

// File: rtl/sub_port_validator_props.sv
module sub_port_validator_props
  import sub_pkg::*;
#(
  parameter int DESC = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            go,
  input logic            out_valid,
  input logic            out_ready,
  input logic [DESC-1:0] out_desc,
  input logic            out_first,
  input logic            out_deep,
  input logic            busy,
  input logic            err_pulse,
  input logic [2:0]      err_code,
  input logic            overrun
);
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_desc)
                                   && $stable(out_first) && $stable(out_deep)));

  p_issued_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_desc[VALID_POS] && out_desc[PRIV_POS]));

  p_mode_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_desc[MODE_LO +: MODE_W] == MODE_SHALLOW && !out_deep) ||
                   (out_desc[MODE_LO +: MODE_W] == MODE_DEEP && out_deep)));

  p_first_lead_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_first);

  p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> ($past(busy) && $past(go)));

  p_err_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_code >= 3'd1 && err_code <= 3'd4 && !busy));
endmodule

bind sub_port_validator sub_port_validator_props #(.DESC(DESC)) u_props (
  .clk(clk), .rst_n(rst_n), .go(go), .out_valid(out_valid),
  .out_ready(out_ready), .out_desc(out_desc), .out_first(out_first),
  .out_deep(out_deep), .busy(busy), .err_pulse(err_pulse),
  .err_code(err_code), .overrun(overrun)
);

// File: tb/sub_port_validator_bench.sv
module sub_port_validator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dw_we = 1'b0;
  logic [1:0]  dw_sel = '0;
  logic [31:0] dw_data = '0;
  logic        go = 1'b0;
  logic        out_ready = 1'b1;
  logic        out_valid, out_first, out_deep, busy, err_pulse, overrun;
  logic [63:0] out_desc;
  logic [2:0]  err_code;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sub_port_validator u_sub_port_validator (
    .clk(clk), .rst_n(rst_n), .dw_we(dw_we), .dw_sel(dw_sel),
    .dw_data(dw_data), .go(go), .out_valid(out_valid),
    .out_ready(out_ready), .out_desc(out_desc), .out_first(out_first),
    .out_deep(out_deep), .busy(busy), .err_pulse(err_pulse),
    .err_code(err_code), .overrun(overrun)
  );

  // {dw0, dw1, dw2, dw3, expected code[15:0], expected count[15:0]}
  localparam int NV = 10;
  localparam logic [159:0] VEC [NV] = '{
    {32'h0000_0119, 32'h1111_0000, 32'h0000_0109, 32'h2222_0000, 16'd0, 16'd2},
    {32'h0000_0000, 32'h3333_0000, 32'h0000_0119, 32'h4444_0000, 16'd0, 16'd1},
    {32'h0000_0118, 32'h0000_0000, 32'h0000_0108, 32'h0000_0000, 16'd1, 16'd0},
    {32'h0000_0109, 32'h0000_0000, 32'h0000_0108, 32'h0000_0000, 16'd2, 16'd0},
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0009, 32'h0000_0000, 16'd3, 16'd0},
    {32'h0000_0019, 32'h0000_0000, 32'h0000_0109, 32'h0000_0000, 16'd3, 16'd0},
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0101, 32'h0000_0000, 16'd4, 16'd0},
    {32'h0000_0111, 32'h0000_0000, 32'h0000_0109, 32'h0000_0000, 16'd4, 16'd0},
    {32'h0000_0008, 32'h0000_0000, 32'h0000_0018, 32'h0000_0000, 16'd1, 16'd0},
    {32'h0000_0009, 32'h0000_0000, 32'h0000_0008, 32'h0000_0000, 16'd3, 16'd0}
  };

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] c, input logic [31:0] d);
    logic [31:0] w [4];
    w[0] = a; w[1] = b; w[2] = c; w[3] = d;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      dw_we = 1'b1; dw_sel = 2'(k); dw_data = w[k];
    end
    @(negedge clk);
    dw_we = 1'b0;
  endtask

  // strobe for one edge; returns at the following negedge
  task automatic fire();
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(out_valid, 0, "R10 out_valid after reset");
    check(busy, 0, "R10 busy after reset");
    check(err_pulse, 0, "R10 err_pulse after reset");
    check(overrun, 0, "R10 overrun after reset");

    // Vector walk: R1..R7, R10, R11
    for (int v = 0; v < NV; v++) begin
      logic [63:0] d0, d1;
      logic [15:0] code, cnt;
      d0 = {VEC[v][63:32], VEC[v][95:64]};
      d1 = {VEC[v][127:96], VEC[v][159:128]};
      code = VEC[v][31:16];
      cnt = VEC[v][15:0];
      out_ready = 1'b1;
      load(VEC[v][159:128], VEC[v][127:96], VEC[v][95:64], VEC[v][63:32]);
      fire();
      if (code != 0) begin
        check(err_pulse, 1, $sformatf("R3/R4/R5/R6 err_pulse vec %0d", v));
        check(err_code, code[2:0], $sformatf("R3/R4/R5/R6 err_code vec %0d", v));
        check(out_valid, 0, $sformatf("R10 nothing issued vec %0d", v));
        check(busy, 0, $sformatf("R10 busy low on reject vec %0d", v));
        @(negedge clk);
        check(err_pulse, 0, $sformatf("R10 single pulse vec %0d", v));
      end else begin
        check(out_valid, 1, $sformatf("R11 valid after strobe vec %0d", v));
        check(out_desc, d0, $sformatf("R1 desc0 pairing vec %0d", v));
        check(out_first, 1, $sformatf("R7 first flag vec %0d", v));
        check(out_deep, (d0[4:3] == 2'd3), $sformatf("R6 deep desc0 vec %0d", v));
        @(negedge clk);
        if (cnt == 2) begin
          check(out_valid, 1, $sformatf("R7 second issue vec %0d", v));
          check(out_desc, d1, $sformatf("R1 desc1 pairing vec %0d", v));
          check(out_first, 0, $sformatf("R7 later flag clear vec %0d", v));
          check(out_deep, (d1[4:3] == 2'd3), $sformatf("R6 deep desc1 vec %0d", v));
          @(negedge clk);
        end
        check(out_valid, 0, $sformatf("R2/R11 issue count vec %0d", v));
        check(busy, 0, $sformatf("R11 busy falls vec %0d", v));
      end
    end

    // Back-pressure and overrun: R8, R9
    out_ready = 1'b0;
    load(32'h0000_0119, 32'h5555_0000, 32'h0000_0109, 32'h6666_0000);
    fire();
    check(out_valid, 1, "R8 offered under stall");
    @(negedge clk);
    check(out_valid, 1, "R8 valid held");
    check(out_desc, 64'h6666_0000_0000_0109, "R8 desc held");
    check(out_first, 1, "R8 first held");
    fire();
    check(overrun, 1, "R9 overrun pulse");
    check(err_pulse, 0, "R9 no error from ignored strobe");
    check(out_desc, 64'h6666_0000_0000_0109, "R9 issue unchanged");
    @(negedge clk);
    check(overrun, 0, "R9 overrun one cycle");
    out_ready = 1'b1;
    @(negedge clk);
    check(out_desc, 64'h5555_0000_0000_0119, "R9 second after stall");
    check(out_first, 0, "R9 second first flag");
    check(out_deep, 1, "R6 deep after stall");
    @(negedge clk);
    check(out_valid, 0, "R9 no extra issue from ignored strobe");

    // Write on strobe edge not seen: R1
    load(32'h0000_0000, 32'h0, 32'h0000_0109, 32'h7777_0000);
    dw_we = 1'b1; dw_sel = 2'd2; dw_data = 32'h0000_0000;
    fire();
    dw_we = 1'b0;
    check(out_valid, 1, "R1 same-cycle write ignored");
    check(out_desc, 64'h7777_0000_0000_0109, "R1 old desc issued");
    @(negedge clk);
    fire();
    check(err_code, 3'd1, "R1 write landed for next submission");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule